// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is the integer add/subtract datapath of a processor core, together with the four-bit condition flag register that goes with it. In every cycle it takes two operands, an operation code and a flag-write enable. It returns the arithmetic result combinationally in that same cycle. When the enable is set, the flags derived from that result are stored on the rising clock edge.

The unit supports six operations: plain addition, addition with the stored carry, subtraction, subtraction with the stored carry, reverse subtraction (second operand minus first), and reverse subtraction with the stored carry. Every subtraction is carried out as an addition of the inverted subtrahend. For that reason the carry flag after a subtraction means "no borrow".

The datapath width is a parameter, 32 bits by default. A second parameter selects the adder variant: either a behavioural adder split at the most significant bit, or an explicit bit-level ripple chain. The shifter, the immediate operand generation, the register file and the instruction decoding all sit outside this block.

Top module: `arith_flag_unit`

## Requirements
- R1: Operation code 0 (add) gives result = A + B modulo 2^W.
- R2: Operation code 1 (add with carry) gives result = A + B + C modulo 2^W, where C is the stored carry flag.
- R3: Code 2 (subtract) gives A − B. Code 3 (subtract with carry) gives A − B + C − 1. Both results are taken modulo 2^W.
- R4: Code 4 (reverse subtract) gives B − A. Code 5 (reverse subtract with carry) gives B − A + C − 1. Both results are taken modulo 2^W.
- R5: The unused codes 6 and 7 behave exactly like add, for both the result and the flags.
- R6: On an enabled edge, the negative flag takes the most significant bit of the result.
- R7: On an enabled edge, the zero flag is set exactly when all result bits are zero.
- R8: On an enabled edge, the carry flag takes the carry out of the MSB of the internal addition. For the subtraction codes this is 1 exactly when the minuend is greater than or equal to the subtrahend, compared unsigned.
- R9: On an enabled edge, the overflow flag is the carry into the MSB XOR the carry out of the MSB. It is therefore set exactly when the true signed result lies outside the W-bit two's complement range.
- R10: With the flag-write enable low, all four flags keep their values, while the result is still produced.
- R11: An active-low synchronous reset clears all four flags at the clock edge, whatever the enable is. The result stays combinational during reset.
- R12: In a cycle where a carry-using operation also writes the flags, the result uses the carry stored before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code (0 add, 1 add+C, 2 sub, 3 sub+C, 4 rsub, 5 rsub+C) |
| flag_we | input | 1 | Store new flags at the next edge |
| result | output | WIDTH | Combinational arithmetic result |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
Two functions can fall in the same cycle: reading the stored carry into a carry-using operation, and overwriting that same carry through an enabled flag write.

The bench provokes this case deliberately. Before each vector it primes the carry with a flag-writing addition. It then applies every operation to all operand pairs at 4 bits, with the enable alternating, so that half of the carry-using vectors also write the flags. The result is sampled between edges and judged against the carry the reference model held before the edge. The flags are then judged after the edge against the model's new values.

A flag write combined with a synchronous reset in one cycle is judged the same way: the reset must win.

// File: rtl/arith_flag_pkg.sv
`timescale 1ns/1ps
package arith_flag_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADC  = 3'd1,
      OP_SUB  = 3'd2,
      OP_SBC  = 3'd3,
      OP_RSB  = 3'd4,
      OP_RSC  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } arith_op_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } cc_flags_t;

   localparam int unsigned OP_SEL_W = 3;

endpackage

// File: rtl/operand_steer.sv
`timescale 1ns/1ps
// Selects operand order, inversion and carry-in so that every operation
// reduces to a single x + y + cin addition.
module operand_steer
   import arith_flag_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0]    a_i,
   input  logic [WIDTH-1:0]    b_i,
   input  logic [OP_SEL_W-1:0] op_i,
   input  logic                carry_q_i,
   output logic [WIDTH-1:0]    x_o,
   output logic [WIDTH-1:0]    y_o,
   output logic                cin_o
);

   arith_op_e op_e;
   logic      swap;
   logic      invert;

   assign op_e = arith_op_e'(op_i);

   always_comb begin
      swap   = 1'b0;
      invert = 1'b0;
      cin_o  = 1'b0;
      unique case (op_e)
         OP_ADD: begin
            cin_o = 1'b0;
         end
         OP_ADC: begin
            cin_o = carry_q_i;
         end
         OP_SUB: begin
            invert = 1'b1;
            cin_o  = 1'b1;
         end
         OP_SBC: begin
            invert = 1'b1;
            cin_o  = carry_q_i;
         end
         OP_RSB: begin
            swap   = 1'b1;
            invert = 1'b1;
            cin_o  = 1'b1;
         end
         OP_RSC: begin
            swap   = 1'b1;
            invert = 1'b1;
            cin_o  = carry_q_i;
         end
         default: begin
            cin_o = 1'b0;
         end
      endcase
   end

   // swap happens before the inverter so carry/overflow describe b - a
   always_comb begin
      x_o = swap ? b_i : a_i;
      y_o = swap ? a_i : b_i;
      if (invert) begin
         y_o = ~y_o;
      end
   end

endmodule

// File: rtl/carry_adder.sv
`timescale 1ns/1ps
// W-bit adder that exposes both the carry into and out of the MSB.
module carry_adder #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned STYLE = 0   // 0: split behavioural, 1: bit ripple
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             c_msb_in_o,
   output logic             c_out_o
);

   localparam int unsigned LOW_W = WIDTH - 1;

   generate
      if (STYLE == 0) begin : g_split
         logic [LOW_W:0] low_ext;
         logic [1:0]     top_ext;

         assign low_ext = {1'b0, x_i[LOW_W-1:0]}
                        + {1'b0, y_i[LOW_W-1:0]}
                        + {{LOW_W{1'b0}}, cin_i};
         assign top_ext = {1'b0, x_i[WIDTH-1]}
                        + {1'b0, y_i[WIDTH-1]}
                        + {1'b0, low_ext[LOW_W]};

         assign sum_o      = {top_ext[0], low_ext[LOW_W-1:0]};
         assign c_msb_in_o = low_ext[LOW_W];
         assign c_out_o    = top_ext[1];
      end else begin : g_ripple
         logic [WIDTH:0] chain;

         assign chain[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]     = x_i[i] ^ y_i[i] ^ chain[i];
            assign chain[i+1]   = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
         end
         assign c_msb_in_o = chain[WIDTH-1];
         assign c_out_o    = chain[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/flag_gen.sv
`timescale 1ns/1ps
// Derives the four condition flags from the adder outputs.
module flag_gen
   import arith_flag_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] sum_i,
   input  logic             c_msb_in_i,
   input  logic             c_out_i,
   output cc_flags_t        flags_o
);

   always_comb begin
      flags_o.neg   = sum_i[WIDTH-1];
      flags_o.zero  = ~|sum_i;
      flags_o.carry = c_out_i;
      flags_o.ovf   = c_msb_in_i ^ c_out_i;
   end

endmodule

// File: rtl/flag_reg.sv
`timescale 1ns/1ps
// Condition flag storage with write enable and synchronous reset.
module flag_reg
   import arith_flag_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we_i,
   input  cc_flags_t d_i,
   output cc_flags_t q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (we_i) begin
         q_o <= d_i;
      end
   end

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o))
      else $error("flags changed without write enable");

   a_r11_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (q_o == '0))
      else $error("flags not cleared by reset");

endmodule

// File: rtl/arith_flag_unit.sv
`timescale 1ns/1ps
// Add/subtract unit with a four-bit condition flag register.
module arith_flag_unit
   import arith_flag_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [WIDTH-1:0]    op_a,
   input  logic [WIDTH-1:0]    op_b,
   input  logic [OP_SEL_W-1:0] op_sel,
   input  logic                flag_we,
   output logic [WIDTH-1:0]    result,
   output logic                flag_n,
   output logic                flag_z,
   output logic                flag_c,
   output logic                flag_v
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("arith_flag_unit: WIDTH must be at least 2");
      end
      if (ADDER_STYLE > 1) begin : g_bad_style
         $error("arith_flag_unit: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] add_sum;
   logic             add_c_msb_in;
   logic             add_c_out;
   cc_flags_t        flags_next;
   cc_flags_t        flags_q;

   operand_steer #(.WIDTH(WIDTH)) u_steer (
      .a_i       (op_a),
      .b_i       (op_b),
      .op_i      (op_sel),
      .carry_q_i (flags_q.carry),
      .x_o       (add_x),
      .y_o       (add_y),
      .cin_o     (add_cin)
   );

   carry_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_adder (
      .x_i        (add_x),
      .y_i        (add_y),
      .cin_i      (add_cin),
      .sum_o      (add_sum),
      .c_msb_in_o (add_c_msb_in),
      .c_out_o    (add_c_out)
   );

   flag_gen #(.WIDTH(WIDTH)) u_flags (
      .sum_i      (add_sum),
      .c_msb_in_i (add_c_msb_in),
      .c_out_i    (add_c_out),
      .flags_o    (flags_next)
   );

   flag_reg u_flag_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (flag_we),
      .d_i   (flags_next),
      .q_o   (flags_q)
   );

   assign result = add_sum;
   assign flag_n = flags_q.neg;
   assign flag_z = flags_q.zero;
   assign flag_c = flags_q.carry;
   assign flag_v = flags_q.ovf;

   a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_ADD) |-> (result == op_a + op_b))
      else $error("add result mismatch");

   a_r6_negative: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flag_n == $past(result[WIDTH-1])))
      else $error("negative flag mismatch");

   a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flag_z == ($past(result) == '0)))
      else $error("zero flag mismatch");

   a_r8_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == OP_SUB) |=> (flag_c == ($past(op_a) >= $past(op_b))))
      else $error("carry after subtract is not no-borrow");

   a_r9_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == OP_ADD) |=>
         (flag_v == (($past(op_a[WIDTH-1]) == $past(op_b[WIDTH-1])) &&
                     ($past(result[WIDTH-1]) != $past(op_a[WIDTH-1])))))
      else $error("overflow after add mismatch");

endmodule

// File: tb/arith_flag_unit_test.sv
`timescale 1ns/1ps
module arith_flag_unit_test;

   localparam int W    = 4;
   localparam int MOD  = 1 << W;
   localparam int SMAX = (1 << (W - 1)) - 1;
   localparam int SMIN = -(1 << (W - 1));

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [2:0]   op_sel = '0;
   logic         flag_we = 1'b0;
   logic [W-1:0] result, result_rip;
   logic         flag_n, flag_z, flag_c, flag_v;
   logic         rn, rz, rc, rv;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model state
   int m_n = 0, m_z = 0, m_c = 0, m_v = 0;

   always #5 clk = ~clk;

   arith_flag_unit #(.WIDTH(W), .ADDER_STYLE(0)) uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .flag_we(flag_we), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v));

   arith_flag_unit #(.WIDTH(W), .ADDER_STYLE(1)) uut_rip (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .flag_we(flag_we), .result(result_rip),
      .flag_n(rn), .flag_z(rz), .flag_c(rc), .flag_v(rv));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string op_tag(input int op, input int we);
      case (op)
         1: op_tag = (we != 0) ? "R2/R12 adc" : "R2 adc";
         2: op_tag = "R3 sub";
         3: op_tag = (we != 0) ? "R3/R12 sbc" : "R3 sbc";
         4: op_tag = "R4 rsb";
         5: op_tag = (we != 0) ? "R4/R12 rsc" : "R4 rsc";
         6, 7: op_tag = "R5 spare code";
         default: op_tag = "R1 add";
      endcase
   endfunction

   // integer reference: unsigned full sum and true signed result
   task automatic model(input int op, input int a, input int b, input int c,
                        output int res, output int n, output int z,
                        output int cf, output int v);
      int sa, sb, full, sfull;
      sa = (a > SMAX) ? a - MOD : a;
      sb = (b > SMAX) ? b - MOD : b;
      case (op)
         1: begin full = a + b + c;             sfull = sa + sb + c;     end
         2: begin full = a + (MOD - 1 - b) + 1; sfull = sa - sb;         end
         3: begin full = a + (MOD - 1 - b) + c; sfull = sa - sb - 1 + c; end
         4: begin full = b + (MOD - 1 - a) + 1; sfull = sb - sa;         end
         5: begin full = b + (MOD - 1 - a) + c; sfull = sb - sa - 1 + c; end
         default: begin full = a + b;           sfull = sa + sb;         end
      endcase
      res = full % MOD;
      n   = (res >= (MOD / 2)) ? 1 : 0;
      z   = (res == 0) ? 1 : 0;
      cf  = (full >= MOD) ? 1 : 0;
      v   = (sfull > SMAX || sfull < SMIN) ? 1 : 0;
   endtask

   task automatic check_flags(input int we_flag);
      if (we_flag != 0) begin
         check("R6 negative", int'(flag_n), m_n);
         check("R7 zero", int'(flag_z), m_z);
         check("R8 carry", int'(flag_c), m_c);
         check("R9 overflow", int'(flag_v), m_v);
      end else begin
         check("R10 hold", int'({flag_n, flag_z, flag_c, flag_v}),
               (m_n << 3) | (m_z << 2) | (m_c << 1) | m_v);
      end
      check("R9 ripple variant flags", int'({rn, rz, rc, rv}),
            (m_n << 3) | (m_z << 2) | (m_c << 1) | m_v);
   endtask

   // one cycle: drive after negedge, check result mid-cycle, flags after edge
   task automatic step(input int op, input int a, input int b, input int we,
                       input int rst);
      int res, n, z, cf, v;
      @(negedge clk);
      op_sel  = 3'(op);
      op_a    = W'(a);
      op_b    = W'(b);
      flag_we = (we != 0);
      rst_n   = (rst == 0);
      #2;
      model(op, a, b, m_c, res, n, z, cf, v);
      check(op_tag(op, we), int'(result), res);
      check("R1 ripple variant result", int'(result_rip), res);
      @(posedge clk);
      if (rst != 0) begin
         m_n = 0; m_z = 0; m_c = 0; m_v = 0;
      end else if (we != 0) begin
         m_n = n; m_z = z; m_c = cf; m_v = v;
      end
      #1;
      if (rst != 0) begin
         check("R11 reset clears flags", int'({flag_n, flag_z, flag_c, flag_v}), 0);
      end else begin
         check_flags(we);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset state", int'({flag_n, flag_z, flag_c, flag_v}), 0);

      // directed: 0101+0110 -> 1011, V=1 C=0
      step(0, 5, 6, 1, 0);
      check("R9 5+6 overflow", int'(flag_v), 1);
      // 1111+0010 -> 0001, C=1 V=0
      step(0, 15, 2, 1, 0);
      check("R8 15+2 carry", int'(flag_c), 1);
      // 1011+1001 -> 0100, C=1 V=1
      step(0, 11, 9, 1, 0);
      check("R9 -5+-7 overflow", int'(flag_v), 1);
      // enabled write together with reset: reset wins, result unaffected
      step(0, 5, 6, 1, 1);
      step(0, 0, 0, 0, 0);

      // exhaustive: every op, operand pair, stored carry value
      for (int c = 0; c < 2; c++) begin
         for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < MOD; a++) begin
               for (int b = 0; b < MOD; b++) begin
                  step(0, (c != 0) ? MOD - 1 : 0, (c != 0) ? 1 : 0, 1, 0);
                  step(op, a, b, (a ^ b ^ op) & 1, 0);
               end
            end
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule